// File: doc/BRIEF.md
# Shared-Memory Setup Message Sequencer

This block sits behind the byte stream that a coordination server sends to a shared-memory device. It gathers the bytes into 64-bit little-endian signed messages. Each message comes with a flag that says whether a descriptor travelled with it. The block then runs the setup protocol and the tracking of peers. The first message carries the protocol version. The second carries the identity of the local device. After that, each message is one of three kinds: a grant of the shared memory (value -1), a peer connect (non-negative value with a descriptor) or a peer disconnect (non-negative value without one).

For a connect, the vector number is implicit: it is the number of connects that peer has already sent. The block keeps one small counter per peer slot. When a connect names the local device, the block reports the vector that was just set up, so that interrupt setup can proceed for it. The block also tracks the logical peer count: it starts at a parameterised size and grows whenever a message names a peer beyond it. It decides the master role from the role selection and the local identity.

Any protocol violation is reported with an encoded cause. Before the grant, a violation ends setup for good. After the grant, a violation is reported and the message has no other effect.

Top module: `shm_setup_seq`

## Requirements
- R1: Bytes accepted with `rx_valid` are assembled little-endian: the first byte of a message is bits 7:0. The eighth byte completes the message, and the byte count returns to zero. `rx_has_desc` is sampled together with that eighth byte. Idle cycles between bytes do not matter, and a reset restarts assembly. Every result of a message appears at the clock edge that takes its eighth byte.
- R2: The first message must equal `PROTO_VER` and carry no descriptor. Otherwise setup fails with cause code 1.
- R3: The second message is the local identity. It must carry no descriptor and lie in 0..`ID_MAX`. Otherwise setup fails with cause code 2. On success, `id_valid` rises and `local_id` holds the value.
- R4: `role_mode` is sampled with the identity message. 0 means never master. 1 means forced master, and an identity other than 0 then fails setup with cause code 7. 2 or 3 means automatic: master exactly when the identity is 0.
- R5: After the identity message, a value below -1 or above `ID_MAX` is rejected with cause code 3 and changes nothing else.
- R6: The value -1 grants the shared memory and raises `setup_done`. A later grant is rejected with cause code 4, and `setup_done` stays high.
- R7: A connect uses the peer's current count as the vector number and then adds one to the count. For the local identity, `vec_ready` pulses for one cycle with `vec_index` equal to that vector number. A connect to a peer whose count has already reached `VECTORS` is rejected with cause code 5.
- R8: A disconnect sets that peer's count back to zero. A disconnect that names the local identity is rejected with cause code 6.
- R9: `peer_limit` resets to `INIT_PEERS`. A connect or disconnect that names a peer at or beyond it sets it to that peer plus one. This happens before the message is checked. The value never decreases.
- R10: `err_valid` pulses for one cycle with a non-zero `err_code`. While no error is reported, `err_code` is 0. An error before the grant raises `setup_failed`, which stays high; every later message is then ignored. An error after the grant leaves the setup state as it was.
- R11: After reset, `setup_done`, `setup_failed`, `id_valid`, `is_master`, `err_valid` and `vec_ready` are 0, and `peer_limit` equals `INIT_PEERS`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A stream byte is present this cycle |
| rx_byte | input | 8 | Stream byte |
| rx_has_desc | input | 1 | Descriptor attached; sampled with the eighth byte |
| role_mode | input | 2 | 0 never master, 1 forced master, 2/3 automatic |
| setup_done | output | 1 | Shared memory granted and setup complete |
| setup_failed | output | 1 | Setup aborted; sticky until reset |
| id_valid | output | 1 | Local identity captured |
| local_id | output | 16 | Local identity |
| is_master | output | 1 | Device holds the master role |
| peer_limit | output | 17 | Current logical peer count |
| err_valid | output | 1 | One-cycle error report |
| err_code | output | 3 | Error cause, 0 when none |
| vec_ready | output | 1 | One-cycle pulse: a local vector was set up |
| vec_index | output | VIDX_W | Local vector number that was set up |

## Verification
On every cycle, the bound checker enforces these invariants:
- `setup_done` and `setup_failed` are never high together, and both stay high once set.
- The peer count never shrinks and never falls below its starting size.
- An error pulse always carries a cause.
- A reported vector is below the vector count and only follows a captured identity.
- The master role implies identity 0.

Only the bench's message sequences can show the rest:
- the byte order;
- the ordering rules for version and identity;
- that vector numbers come out in connect order;
- that a disconnect re-arms a peer's counter;
- that a failed setup swallows later messages.

// File: rtl/shm_seq_pkg.sv
package shm_seq_pkg;

    localparam int ID_W  = 16;
    localparam int MSG_W = 64;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_VERSION   = 3'd1,
        ERR_ID        = 3'd2,
        ERR_RANGE     = 3'd3,
        ERR_DUP_GRANT = 3'd4,
        ERR_VEC_FULL  = 3'd5,
        ERR_DISC      = 3'd6,
        ERR_ROLE      = 3'd7
    } err_e;

    typedef enum logic [1:0] {
        PH_VER  = 2'd0,
        PH_ID   = 2'd1,
        PH_RUN  = 2'd2,
        PH_DEAD = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        K_BAD        = 2'd0,
        K_GRANT      = 2'd1,
        K_CONNECT    = 2'd2,
        K_DISCONNECT = 2'd3
    } kind_e;

    typedef struct packed {
        logic signed [MSG_W-1:0] value;
        logic                    desc;
    } msg_t;

    typedef struct packed {
        logic take_id;
        logic grant;
        logic grow;
        logic inc;
        logic clr;
        logic announce;
    } act_t;

    // Sort a message received after the identity phase.
    function automatic kind_e classify(input msg_t m, input logic signed [MSG_W-1:0] top);
        if (m.value < -64'sd1)  return K_BAD;
        if (m.value == -64'sd1) return K_GRANT;
        if (m.value > top)      return K_BAD;
        return m.desc ? K_CONNECT : K_DISCONNECT;
    endfunction

    function automatic logic role_forced(input logic [1:0] r);
        return r == 2'd1;
    endfunction

    function automatic logic role_auto(input logic [1:0] r);
        return r[1];
    endfunction

endpackage

// File: rtl/shm_byte_gather.sv
module shm_byte_gather
    import shm_seq_pkg::*;
#(
    parameter int MSG_BYTES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic [7:0] in_byte,
    input  logic in_desc,
    output logic out_fire,
    output msg_t out_msg
);
    localparam int HELD_W = 8 * (MSG_BYTES - 1);
    localparam int CNT_W  = $clog2(MSG_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MSG_BYTES - 1);

    logic [HELD_W-1:0] held_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            cnt_q  <= '0;
        end else if (in_valid) begin
            held_q <= {in_byte, held_q[HELD_W-1:8]};
            cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // The final byte goes straight to the top of the word, so the message is
    // handled at the edge that takes it.
    always_comb begin
        out_fire      = in_valid && (cnt_q == LAST);
        out_msg.value = {in_byte, held_q};
        out_msg.desc  = in_desc;
    end

endmodule

// File: rtl/shm_vec_table.sv
module shm_vec_table
    import shm_seq_pkg::*;
#(
    parameter int SLOTS = 64,
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic [ID_W-1:0] sel,
    input  logic inc,
    input  logic clr,
    output logic [CNT_W-1:0] cur_cnt
);
    logic [SLOTS*CNT_W-1:0] flat;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [CNT_W-1:0] c_q;
        logic             hit;
        assign hit = (sel == ID_W'(g));
        always_ff @(posedge clk) begin
            if (rst)              c_q <= '0;
            else if (hit && clr)  c_q <= '0;
            else if (hit && inc)  c_q <= c_q + CNT_W'(1);
        end
        assign flat[g*CNT_W +: CNT_W] = c_q;
    end

    always_comb begin
        cur_cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (sel == ID_W'(i)) cur_cnt = flat[i*CNT_W +: CNT_W];
        end
    end

endmodule

// File: rtl/shm_msg_judge.sv
module shm_msg_judge
    import shm_seq_pkg::*;
#(
    parameter longint PROTO_VER = 0,
    parameter int     ID_MAX    = 63,
    parameter int     VECTORS   = 4,
    parameter int     CNT_W     = 3
) (
    input  phase_e          phase,
    input  logic            done,
    input  msg_t            msg,
    input  logic [ID_W-1:0] local_id,
    input  logic [ID_W:0]   peer_limit,
    input  logic [CNT_W-1:0] cur_cnt,
    input  logic [1:0]      role,
    output err_e            err,
    output act_t            act
);
    localparam logic signed [MSG_W-1:0] TOP_S = MSG_W'(ID_MAX);
    localparam logic signed [MSG_W-1:0] VER_S = MSG_W'(PROTO_VER);

    logic [ID_W-1:0] peer;
    logic            beyond;
    logic            full;

    assign peer   = msg.value[ID_W-1:0];
    assign beyond = {1'b0, peer} >= peer_limit;
    assign full   = cur_cnt >= CNT_W'(VECTORS);

    always_comb begin
        err = ERR_NONE;
        act = '0;
        unique case (phase)
            PH_VER: begin
                if (msg.desc || msg.value != VER_S) err = ERR_VERSION;
            end
            PH_ID: begin
                if (msg.desc || msg.value < 64'sd0 || msg.value > TOP_S)
                    err = ERR_ID;
                else if (role_forced(role) && peer != '0)
                    err = ERR_ROLE;
                else
                    act.take_id = 1'b1;
            end
            PH_RUN: begin
                unique case (classify(msg, TOP_S))
                    K_BAD:   err = ERR_RANGE;
                    K_GRANT: begin
                        if (done) err = ERR_DUP_GRANT;
                        else      act.grant = 1'b1;
                    end
                    K_CONNECT: begin
                        act.grow = beyond;
                        if (full) begin
                            err = ERR_VEC_FULL;
                        end else begin
                            act.inc      = 1'b1;
                            act.announce = (peer == local_id);
                        end
                    end
                    K_DISCONNECT: begin
                        act.grow = beyond;
                        if (peer == local_id) err = ERR_DISC;
                        else                  act.clr = 1'b1;
                    end
                endcase
            end
            PH_DEAD: ;
        endcase
    end

endmodule

// File: rtl/shm_setup_seq.sv
module shm_setup_seq
    import shm_seq_pkg::*;
#(
    parameter longint PROTO_VER  = 0,
    parameter int     ID_MAX     = 63,
    parameter int     VECTORS    = 4,
    parameter int     INIT_PEERS = 16,
    localparam int    VIDX_W     = (VECTORS > 1) ? $clog2(VECTORS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_has_desc,
    input  logic [1:0]        role_mode,
    output logic              setup_done,
    output logic              setup_failed,
    output logic              id_valid,
    output logic [ID_W-1:0]   local_id,
    output logic              is_master,
    output logic [ID_W:0]     peer_limit,
    output logic              err_valid,
    output logic [2:0]        err_code,
    output logic              vec_ready,
    output logic [VIDX_W-1:0] vec_index
);
    localparam int SLOTS = ID_MAX + 1;
    localparam int CNT_W = $clog2(VECTORS + 1);
    localparam int LIM_W = ID_W + 1;

    logic fire;
    msg_t msg;
    logic [CNT_W-1:0] cur_cnt;
    err_e err;
    act_t act;
    logic take;

    phase_e phase_q;
    logic done_q, idv_q, master_q, errv_q, vrdy_q;
    err_e code_q;
    logic [ID_W-1:0]  lid_q;
    logic [LIM_W-1:0] lim_q;
    logic [VIDX_W-1:0] vidx_q;

    shm_byte_gather #(.MSG_BYTES(8)) u_gather (
        .clk(clk), .rst(rst), .in_valid(rx_valid), .in_byte(rx_byte),
        .in_desc(rx_has_desc), .out_fire(fire), .out_msg(msg)
    );

    shm_msg_judge #(
        .PROTO_VER(PROTO_VER), .ID_MAX(ID_MAX), .VECTORS(VECTORS), .CNT_W(CNT_W)
    ) u_judge (
        .phase(phase_q), .done(done_q), .msg(msg), .local_id(lid_q),
        .peer_limit(lim_q), .cur_cnt(cur_cnt), .role(role_mode),
        .err(err), .act(act)
    );

    assign take = fire && (phase_q != PH_DEAD);

    shm_vec_table #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst(rst), .sel(msg.value[ID_W-1:0]),
        .inc(take && act.inc), .clr(take && act.clr), .cur_cnt(cur_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_VER;
            done_q   <= 1'b0;
            idv_q    <= 1'b0;
            master_q <= 1'b0;
            lid_q    <= '0;
            lim_q    <= LIM_W'(INIT_PEERS);
            errv_q   <= 1'b0;
            code_q   <= ERR_NONE;
            vrdy_q   <= 1'b0;
            vidx_q   <= '0;
        end else begin
            errv_q <= 1'b0;
            code_q <= ERR_NONE;
            vrdy_q <= 1'b0;
            if (take) begin
                if (err != ERR_NONE) begin
                    errv_q <= 1'b1;
                    code_q <= err;
                    if (!done_q) phase_q <= PH_DEAD;
                end else if (phase_q == PH_VER) begin
                    phase_q <= PH_ID;
                end else if (phase_q == PH_ID) begin
                    phase_q <= PH_RUN;
                end
                if (act.take_id) begin
                    lid_q    <= msg.value[ID_W-1:0];
                    idv_q    <= 1'b1;
                    master_q <= role_forced(role_mode) ||
                                (role_auto(role_mode) && msg.value[ID_W-1:0] == '0);
                end
                if (act.grant) done_q <= 1'b1;
                if (act.grow)  lim_q  <= LIM_W'(msg.value[ID_W-1:0]) + LIM_W'(1);
                if (act.announce) begin
                    vrdy_q <= 1'b1;
                    vidx_q <= cur_cnt[VIDX_W-1:0];
                end
            end
        end
    end

    assign setup_done   = done_q;
    assign setup_failed = (phase_q == PH_DEAD);
    assign id_valid     = idv_q;
    assign local_id     = lid_q;
    assign is_master    = master_q;
    assign peer_limit   = lim_q;
    assign err_valid    = errv_q;
    assign err_code     = code_q;
    assign vec_ready    = vrdy_q;
    assign vec_index    = vidx_q;

endmodule

// File: rtl/shm_setup_seq_chk.sv
module shm_setup_seq_chk #(
    parameter int VECTORS    = 4,
    parameter int INIT_PEERS = 16,
    parameter int VIDX_W     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              setup_done,
    input logic              setup_failed,
    input logic              id_valid,
    input logic [15:0]       local_id,
    input logic              is_master,
    input logic [16:0]       peer_limit,
    input logic              err_valid,
    input logic [2:0]        err_code,
    input logic              vec_ready,
    input logic [VIDX_W-1:0] vec_index
);
    assert_done_fail_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(setup_done && setup_failed));

    assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        setup_failed |=> setup_failed);

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        setup_done |=> setup_done);

    assert_limit_monotonic_R9: assert property (@(posedge clk) disable iff (rst)
        peer_limit >= $past(peer_limit));

    assert_limit_floor_R9: assert property (@(posedge clk) disable iff (rst)
        peer_limit >= 17'(INIT_PEERS));

    assert_err_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> err_code != 3'd0);

    assert_idle_code_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !err_valid |-> err_code == 3'd0);

    assert_vec_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        vec_ready |-> (32'(vec_index) < VECTORS));

    assert_vec_after_id_R7: assert property (@(posedge clk) disable iff (rst)
        vec_ready |-> id_valid);

    assert_master_is_zero_R4: assert property (@(posedge clk) disable iff (rst)
        is_master |-> (id_valid && local_id == 16'd0));

endmodule

bind shm_setup_seq shm_setup_seq_chk #(
    .VECTORS(VECTORS), .INIT_PEERS(INIT_PEERS), .VIDX_W(VIDX_W)
) u_chk (
    .clk(clk), .rst(rst), .setup_done(setup_done), .setup_failed(setup_failed),
    .id_valid(id_valid), .local_id(local_id), .is_master(is_master),
    .peer_limit(peer_limit), .err_valid(err_valid), .err_code(err_code),
    .vec_ready(vec_ready), .vec_index(vec_index)
);

// File: tb/shm_setup_seq_bench.sv
`timescale 1ns/1ps
module shm_setup_seq_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_has_desc = 1'b0;
    logic [1:0] role_mode = 2'd2;
    logic setup_done, setup_failed, id_valid, is_master, err_valid, vec_ready;
    logic [15:0] local_id;
    logic [16:0] peer_limit;
    logic [2:0] err_code;
    logic [1:0] vec_index;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    shm_setup_seq u_shm_setup_seq (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_has_desc(rx_has_desc), .role_mode(role_mode),
        .setup_done(setup_done), .setup_failed(setup_failed), .id_valid(id_valid),
        .local_id(local_id), .is_master(is_master), .peer_limit(peer_limit),
        .err_valid(err_valid), .err_code(err_code), .vec_ready(vec_ready),
        .vec_index(vec_index)
    );

    // value, descriptor, expected cause, vector pulse, vector number, peer count, done
    typedef struct packed {
        logic [63:0] v;
        logic        d;
        logic [2:0]  code;
        logic        vr;
        logic [1:0]  idx;
        logic [16:0] lim;
        logic        done;
    } row_t;

    localparam int NROWS = 24;
    localparam row_t ROWS [NROWS] = '{
        '{64'd0,  1'b0, 3'd0, 1'b0, 2'd0, 17'd16, 1'b0},
        '{64'd3,  1'b0, 3'd0, 1'b0, 2'd0, 17'd16, 1'b0},
        '{64'd3,  1'b1, 3'd0, 1'b1, 2'd0, 17'd16, 1'b0},
        '{64'd3,  1'b1, 3'd0, 1'b1, 2'd1, 17'd16, 1'b0},
        '{64'd20, 1'b1, 3'd0, 1'b0, 2'd0, 17'd21, 1'b0},
        '{64'd3,  1'b1, 3'd0, 1'b1, 2'd2, 17'd21, 1'b0},
        '{64'd3,  1'b1, 3'd0, 1'b1, 2'd3, 17'd21, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'd0, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd3,  1'b1, 3'd5, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'd4, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd100, 1'b0, 3'd3, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 3'd3, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'h0100_0000_0000_0003, 1'b1, 3'd3, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd3,  1'b0, 3'd6, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd7,  1'b1, 3'd0, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd7,  1'b1, 3'd0, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd7,  1'b1, 3'd0, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd7,  1'b1, 3'd0, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd7,  1'b1, 3'd5, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd7,  1'b0, 3'd0, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd7,  1'b1, 3'd0, 1'b0, 2'd0, 17'd21, 1'b1},
        '{64'd40, 1'b0, 3'd0, 1'b0, 2'd0, 17'd41, 1'b1},
        '{64'd63, 1'b1, 3'd0, 1'b0, 2'd0, 17'd64, 1'b1},
        '{64'd64, 1'b1, 3'd3, 1'b0, 2'd0, 17'd64, 1'b1}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drive_byte(input logic [7:0] b, input logic d);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte = b;
        rx_has_desc = d;
    endtask

    // Sends one message; gap idle cycles follow each of the first seven bytes.
    task automatic send(input logic [63:0] v, input logic d, input int gap);
        for (int b = 0; b < 8; b++) begin
            drive_byte(v[8*b +: 8], (b == 7) ? d : 1'b0);
            if (gap > 0 && b < 7) begin
                @(negedge clk);
                rx_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_has_desc = 1'b0;
    endtask

    task automatic expect_err(input string req, input logic [2:0] code);
        check(err_valid == (code != 3'd0), req, "err_valid", err_valid, code != 3'd0);
        check(err_code == code, req, "err_code", err_code, code);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        role_mode = 2'd2;
        do_reset();
        check(setup_done == 0, "R11", "setup_done", setup_done, 0);
        check(setup_failed == 0, "R11", "setup_failed", setup_failed, 0);
        check(id_valid == 0, "R11", "id_valid", id_valid, 0);
        check(is_master == 0, "R11", "is_master", is_master, 0);
        check(err_valid == 0 && vec_ready == 0, "R11", "pulses", {err_valid, vec_ready}, 0);
        check(peer_limit == 17'd16, "R11", "peer_limit", peer_limit, 16);

        // Table walk: R1 byte order and gaps, R5..R9 run-time behaviour
        for (int i = 0; i < NROWS; i++) begin
            send(ROWS[i].v, ROWS[i].d, i % 3);
            expect_err("R5_R6_R7_R8 table", ROWS[i].code);
            check(vec_ready == ROWS[i].vr, "R7", "vec_ready", vec_ready, ROWS[i].vr);
            if (ROWS[i].vr)
                check(vec_index == ROWS[i].idx, "R7", "vec_index", vec_index, ROWS[i].idx);
            check(peer_limit == ROWS[i].lim, "R9", "peer_limit", peer_limit, ROWS[i].lim);
            check(setup_done == ROWS[i].done, "R6", "setup_done", setup_done, ROWS[i].done);
            check(setup_failed == 0, "R10", "setup_failed", setup_failed, 0);
            if (i == 1) begin
                check(id_valid == 1 && local_id == 16'd3, "R3", "local_id", local_id, 3);
                check(is_master == 0, "R4", "auto role id 3", is_master, 0);
            end
        end

        // R2: wrong version fails; R10: later messages are ignored
        do_reset();
        send(64'd5, 1'b0, 0);
        expect_err("R2", 3'd1);
        check(setup_failed == 1, "R2", "setup_failed", setup_failed, 1);
        send(64'd0, 1'b0, 0);
        check(err_valid == 0 && id_valid == 0, "R10", "ignored after fail",
              {err_valid, id_valid}, 0);
        check(setup_failed == 1, "R10", "failed sticky", setup_failed, 1);

        // R2: correct version but with descriptor
        do_reset();
        send(64'd0, 1'b1, 1);
        expect_err("R2", 3'd1);

        // R3: identity out of range, negative, and with descriptor
        do_reset();
        send(64'd0, 1'b0, 0);
        send(64'd64, 1'b0, 0);
        expect_err("R3", 3'd2);
        check(id_valid == 0 && setup_failed == 1, "R3", "id rejected",
              {id_valid, setup_failed}, 1);
        do_reset();
        send(64'd0, 1'b0, 0);
        send(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0);
        expect_err("R3", 3'd2);
        do_reset();
        send(64'd0, 1'b0, 0);
        send(64'd2, 1'b1, 0);
        expect_err("R3", 3'd2);

        // R4: role handling
        role_mode = 2'd1;
        do_reset();
        send(64'd0, 1'b0, 0);
        send(64'd2, 1'b0, 0);
        expect_err("R4", 3'd7);
        check(setup_failed == 1, "R4", "forced role id 2 fails", setup_failed, 1);
        do_reset();
        send(64'd0, 1'b0, 0);
        send(64'd0, 1'b0, 0);
        check(is_master == 1 && id_valid == 1, "R4", "forced role id 0", is_master, 1);
        role_mode = 2'd0;
        do_reset();
        send(64'd0, 1'b0, 0);
        send(64'd0, 1'b0, 0);
        check(is_master == 0, "R4", "role off id 0", is_master, 0);
        role_mode = 2'd3;
        do_reset();
        send(64'd0, 1'b0, 0);
        send(64'd0, 1'b0, 0);
        check(is_master == 1, "R4", "auto role id 0", is_master, 1);

        // R10: an error before the grant aborts setup; the grant is then ignored
        role_mode = 2'd2;
        do_reset();
        send(64'd0, 1'b0, 0);
        send(64'd1, 1'b0, 0);
        send(64'd200, 1'b0, 0);
        expect_err("R10", 3'd3);
        check(setup_failed == 1, "R10", "failed before grant", setup_failed, 1);
        send(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0);
        check(setup_done == 0, "R10", "grant ignored", setup_done, 0);

        // R1: reset in the middle of a message restarts assembly
        do_reset();
        for (int b = 0; b < 3; b++) drive_byte(8'hAA, 1'b0);
        do_reset();
        send(64'd0, 1'b0, 0);
        check(err_valid == 0 && setup_failed == 0, "R1", "restart after reset",
              {err_valid, setup_failed}, 0);
        send(64'd9, 1'b0, 2);
        check(id_valid == 1 && local_id == 16'd9, "R1", "id after gaps", local_id, 9);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule